// File: doc/BRIEF.md
# Bridge Transaction Ordering Arbiter

This block sits on one crossing direction of a bus bridge and decides which queued transaction is handed next to the master on the target side. It holds two queues of eight entries each. One holds posted writes. The other holds delayed transactions: read requests, write requests, read completions and write completions. Each entry carries only an address and a tag, and delayed entries also carry a kind code. Data stays outside the block.

Ordering works as follows. Each delayed entry records how many posted writes were still queued ahead of it when it arrived. The count drops each time a posted write is reported done. Read requests, write requests and read completions stay ineligible until that count reaches zero. Write completions ignore the count. Posted writes never wait on delayed entries. When both queue heads are eligible, the two queues take turns.

The master interface works in three steps. The block offers one transaction with a valid/ready handshake. While that transaction is outstanding, the block offers nothing more. The master then returns a one-cycle done or retry pulse. Done removes the entry from its queue. Retry leaves the entry where it is. Either response hands priority to the other queue.

Top module: `xbr_order_arb`

## Requirements
- R1: Posted writes are offered on the issue port in the order they were accepted on the posted push port.
- R2: A delayed entry of kind 0 (read request) is not offered until every posted write accepted in an earlier cycle has received a done response.
- R3: A delayed entry of kind 2 (read completion) is not offered until every posted write accepted in an earlier cycle has received a done response.
- R4: A delayed entry of kind 1 (write request) is not offered until every posted write accepted in an earlier cycle has received a done response.
- R5: A delayed entry of kind 3 (write completion) is eligible regardless of earlier posted writes and may be offered before them.
- R6: Posted writes accepted after a delayed entry may be offered while that delayed entry is waiting or being retried.
- R7: When both queue heads are eligible, the queue holding priority is offered. Priority starts with the posted queue after reset, and every done or retry response passes it to the queue that did not own the response.
- R8: A retry response leaves the entry at the head of its queue, and the entry is offered again later with the same address, tag and kind.
- R9: A done response removes the entry. With both queues empty, iss_valid stays low.
- R10: Each queue holds 8 entries. A full queue drives its push ready low, and a push presented while ready is low is dropped and never issued.
- R11: While iss_valid is high and iss_ready is low, the offered fields stay constant. From acceptance until the done or retry response, iss_valid stays low.
- R12: During and right after reset, iss_valid is low and both push readies are high.
- R13: Delayed entries are offered in the order they were accepted on the delayed push port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pw_push_valid | input | 1 | Posted write push request |
| pw_push_ready | output | 1 | Posted queue has room |
| pw_push_addr | input | AW | Posted write address |
| pw_push_tag | input | TW | Posted write tag |
| dl_push_valid | input | 1 | Delayed entry push request |
| dl_push_ready | output | 1 | Delayed queue has room |
| dl_push_addr | input | AW | Delayed entry address |
| dl_push_tag | input | TW | Delayed entry tag |
| dl_push_kind | input | 2 | 0 read req, 1 write req, 2 read cpl, 3 write cpl |
| iss_valid | output | 1 | Transaction offered to the target master |
| iss_ready | input | 1 | Target master accepts the offer |
| iss_posted | output | 1 | Offered entry comes from the posted queue |
| iss_addr | output | AW | Offered address |
| iss_tag | output | TW | Offered tag |
| iss_kind | output | 2 | Kind of the offered delayed entry, zero for posted |
| rsp_done | input | 1 | Outstanding transaction completed |
| rsp_retry | input | 1 | Outstanding transaction must be retried |

## Verification
The assertions assume a well-behaved master. It pulses rsp_done or rsp_retry for a single cycle, never both together, and only after an offer has been accepted and before the next one. They also assume pushes are held only through the handshake cycle. The shadow occupancy counts in the checker rely on these assumptions. The bench follows them by construction. Every response is raised by the same task that has just completed the acceptance, one cycle after it. Each push task holds valid for exactly one clock, except for the deliberate refused-push stimulus, which is made only while ready is low.

// File: rtl/xbr_order_pkg.sv
package xbr_order_pkg;

    typedef enum logic [1:0] {
        K_RREQ = 2'd0,
        K_WREQ = 2'd1,
        K_RCPL = 2'd2,
        K_WCPL = 2'd3
    } xbr_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_OFFER = 2'd1,
        S_WAIT  = 2'd2
    } xbr_state_e;

    localparam logic Q_PW = 1'b0;
    localparam logic Q_DL = 1'b1;

endpackage

// File: rtl/xbr_fifo.sv
module xbr_fifo #(
    parameter int W     = 40,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  push_ok, pop_ok;

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign count = q.cnt;
    assign head  = q.mem[q.rp];

    always_comb begin
        d       = q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) begin
            d.mem[q.wp] = din;
            d.wp        = q.wp + 1'b1;
        end
        if (pop_ok) begin
            d.rp = q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/xbr_dl_queue.sv
module xbr_dl_queue #(
    parameter int AW    = 32,
    parameter int TW    = 8,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [TW-1:0] push_tag,
    input  logic [1:0]    push_kind,
    input  logic [CW-1:0] push_ahead,
    input  logic          pop,
    input  logic          retire,
    output logic [AW-1:0] head_addr,
    output logic [TW-1:0] head_tag,
    output logic [1:0]    head_kind,
    output logic [CW-1:0] head_ahead,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [TW-1:0] tag;
        logic [1:0]    kind;
        logic [CW-1:0] ahead;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] mem;
        logic [PW-1:0]    wp;
        logic [PW-1:0]    rp;
        logic [CW-1:0]    cnt;
    } dlq_t;

    dlq_t q, d;
    logic push_ok, pop_ok;

    assign full       = (q.cnt == CW'(DEPTH));
    assign empty      = (q.cnt == '0);
    assign head_addr  = q.mem[q.rp].addr;
    assign head_tag   = q.mem[q.rp].tag;
    assign head_kind  = q.mem[q.rp].kind;
    assign head_ahead = q.mem[q.rp].ahead;

    always_comb begin
        d       = q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        // every retired posted write clears one older write from each entry
        for (int i = 0; i < DEPTH; i++) begin
            if (retire && (q.mem[i].ahead != '0)) begin
                d.mem[i].ahead = q.mem[i].ahead - 1'b1;
            end
        end
        if (push_ok) begin
            d.mem[q.wp].addr  = push_addr;
            d.mem[q.wp].tag   = push_tag;
            d.mem[q.wp].kind  = push_kind;
            d.mem[q.wp].ahead = push_ahead;
            d.wp              = q.wp + 1'b1;
        end
        if (pop_ok) begin
            d.rp = q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/xbr_pick.sv
module xbr_pick #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          pw_empty,
    input  logic          dl_empty,
    input  logic [CW-1:0] dl_ahead,
    input  logic [1:0]    dl_kind,
    input  logic          prio,
    output logic          any_elig,
    output logic          pick
);
    import xbr_order_pkg::*;

    logic pw_elig, dl_elig;

    always_comb begin
        pw_elig  = !pw_empty;
        dl_elig  = !dl_empty && ((dl_ahead == '0) || (dl_kind == K_WCPL));
        any_elig = pw_elig || dl_elig;
        if (pw_elig && dl_elig) pick = prio;
        else if (dl_elig)       pick = Q_DL;
        else                    pick = Q_PW;
    end

endmodule

// File: rtl/xbr_order_arb.sv
module xbr_order_arb #(
    parameter int AW    = 32,
    parameter int TW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pw_push_valid,
    output logic          pw_push_ready,
    input  logic [AW-1:0] pw_push_addr,
    input  logic [TW-1:0] pw_push_tag,
    input  logic          dl_push_valid,
    output logic          dl_push_ready,
    input  logic [AW-1:0] dl_push_addr,
    input  logic [TW-1:0] dl_push_tag,
    input  logic [1:0]    dl_push_kind,
    output logic          iss_valid,
    input  logic          iss_ready,
    output logic          iss_posted,
    output logic [AW-1:0] iss_addr,
    output logic [TW-1:0] iss_tag,
    output logic [1:0]    iss_kind,
    input  logic          rsp_done,
    input  logic          rsp_retry
);
    import xbr_order_pkg::*;

    typedef struct packed {
        xbr_state_e st;
        logic       owner;
        logic       prio;
    } arb_t;

    arb_t q, d;

    logic [AW+TW-1:0] pw_head;
    logic             pw_full, pw_empty;
    logic [CW-1:0]    pw_cnt;
    logic [AW-1:0]    dl_addr;
    logic [TW-1:0]    dl_tag;
    logic [1:0]       dl_kind;
    logic [CW-1:0]    dl_ahead;
    logic             dl_full, dl_empty;
    logic             any_elig, pick;
    logic             resp, retire, dl_pop;
    logic [CW-1:0]    push_ahead;

    assign resp       = (q.st == S_WAIT) && (rsp_done || rsp_retry);
    assign retire     = (q.st == S_WAIT) && rsp_done && (q.owner == Q_PW);
    assign dl_pop     = (q.st == S_WAIT) && rsp_done && (q.owner == Q_DL);
    // posted writes still queued after this cycle's retire are older
    assign push_ahead = pw_cnt - CW'(retire);

    xbr_fifo #(.W(AW + TW), .DEPTH(DEPTH)) u_pwq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (pw_push_valid),
        .din   ({pw_push_addr, pw_push_tag}),
        .pop   (retire),
        .head  (pw_head),
        .full  (pw_full),
        .empty (pw_empty),
        .count (pw_cnt)
    );

    xbr_dl_queue #(.AW(AW), .TW(TW), .DEPTH(DEPTH)) u_dlq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (dl_push_valid),
        .push_addr  (dl_push_addr),
        .push_tag   (dl_push_tag),
        .push_kind  (dl_push_kind),
        .push_ahead (push_ahead),
        .pop        (dl_pop),
        .retire     (retire),
        .head_addr  (dl_addr),
        .head_tag   (dl_tag),
        .head_kind  (dl_kind),
        .head_ahead (dl_ahead),
        .full       (dl_full),
        .empty      (dl_empty)
    );

    xbr_pick #(.DEPTH(DEPTH)) u_pick (
        .pw_empty (pw_empty),
        .dl_empty (dl_empty),
        .dl_ahead (dl_ahead),
        .dl_kind  (dl_kind),
        .prio     (q.prio),
        .any_elig (any_elig),
        .pick     (pick)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (any_elig) begin
                    d.st    = S_OFFER;
                    d.owner = pick;
                end
            end
            S_OFFER: begin
                if (iss_ready) d.st = S_WAIT;
            end
            S_WAIT: begin
                if (resp) begin
                    d.st   = S_IDLE;
                    d.prio = ~q.owner;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: S_IDLE, owner: Q_PW, prio: Q_PW};
        else        q <= d;
    end

    assign pw_push_ready = !pw_full;
    assign dl_push_ready = !dl_full;
    assign iss_valid     = (q.st == S_OFFER);
    assign iss_posted    = (q.owner == Q_PW);
    assign iss_addr      = iss_posted ? pw_head[AW+TW-1:TW] : dl_addr;
    assign iss_tag       = iss_posted ? pw_head[TW-1:0] : dl_tag;
    assign iss_kind      = iss_posted ? 2'b00 : dl_kind;

endmodule

// File: rtl/xbr_order_arb_chk.sv
module xbr_order_arb_chk #(
    parameter int AW    = 32,
    parameter int TW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pw_push_valid,
    input logic          pw_push_ready,
    input logic          dl_push_valid,
    input logic          dl_push_ready,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic          iss_posted,
    input logic [AW-1:0] iss_addr,
    input logic [TW-1:0] iss_tag,
    input logic [1:0]    iss_kind,
    input logic          rsp_done,
    input logic          rsp_retry
);

    logic [CW-1:0] pw_occ, dl_occ;
    logic          outst, out_posted;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_occ     <= '0;
            dl_occ     <= '0;
            outst      <= 1'b0;
            out_posted <= 1'b0;
        end else begin
            pw_occ <= pw_occ + CW'(pw_push_valid && pw_push_ready)
                             - CW'(outst && rsp_done && out_posted);
            dl_occ <= dl_occ + CW'(dl_push_valid && dl_push_ready)
                             - CW'(outst && rsp_done && !out_posted);
            if (iss_valid && iss_ready) begin
                outst      <= 1'b1;
                out_posted <= iss_posted;
            end else if (rsp_done || rsp_retry) begin
                outst <= 1'b0;
            end
        end
    end

    p_pw_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_occ == CW'(DEPTH)) |-> !pw_push_ready);
    p_pw_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_occ < CW'(DEPTH)) |-> pw_push_ready);
    p_dl_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_occ == CW'(DEPTH)) |-> !dl_push_ready);
    p_dl_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_occ < CW'(DEPTH)) |-> dl_push_ready);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_addr) && $stable(iss_tag)
                                       && $stable(iss_posted) && $stable(iss_kind)));
    p_one_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
        outst |-> !iss_valid);
    p_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_posted ? (pw_occ != '0) : (dl_occ != '0)));

endmodule

bind xbr_order_arb xbr_order_arb_chk #(.AW(AW), .TW(TW), .DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pw_push_valid (pw_push_valid),
    .pw_push_ready (pw_push_ready),
    .dl_push_valid (dl_push_valid),
    .dl_push_ready (dl_push_ready),
    .iss_valid     (iss_valid),
    .iss_ready     (iss_ready),
    .iss_posted    (iss_posted),
    .iss_addr      (iss_addr),
    .iss_tag       (iss_tag),
    .iss_kind      (iss_kind),
    .rsp_done      (rsp_done),
    .rsp_retry     (rsp_retry)
);

// File: tb/xbr_order_arb_test.sv
`timescale 1ns/1ps
module xbr_order_arb_test;

    localparam int AW = 32;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pw_push_valid = 1'b0;
    logic          pw_push_ready;
    logic [AW-1:0] pw_push_addr = '0;
    logic [TW-1:0] pw_push_tag = '0;
    logic          dl_push_valid = 1'b0;
    logic          dl_push_ready;
    logic [AW-1:0] dl_push_addr = '0;
    logic [TW-1:0] dl_push_tag = '0;
    logic [1:0]    dl_push_kind = '0;
    logic          iss_valid;
    logic          iss_ready = 1'b0;
    logic          iss_posted;
    logic [AW-1:0] iss_addr;
    logic [TW-1:0] iss_tag;
    logic [1:0]    iss_kind;
    logic          rsp_done = 1'b0;
    logic          rsp_retry = 1'b0;

    int  total = 0;
    int  bad   = 0;
    bit  ended = 0;

    always #2.5 clk = ~clk;

    xbr_order_arb #(.AW(AW), .TW(TW), .DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .pw_push_valid(pw_push_valid), .pw_push_ready(pw_push_ready),
        .pw_push_addr(pw_push_addr), .pw_push_tag(pw_push_tag),
        .dl_push_valid(dl_push_valid), .dl_push_ready(dl_push_ready),
        .dl_push_addr(dl_push_addr), .dl_push_tag(dl_push_tag), .dl_push_kind(dl_push_kind),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_posted(iss_posted),
        .iss_addr(iss_addr), .iss_tag(iss_tag), .iss_kind(iss_kind),
        .rsp_done(rsp_done), .rsp_retry(rsp_retry)
    );

    function automatic logic [AW-1:0] addr_of(input logic [TW-1:0] t);
        return 32'h4000_0000 + {24'h0, t} * 32'd16;
    endfunction

    function automatic void check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic push_pw(input logic [TW-1:0] t);
        check(pw_push_ready, "R10 posted ready", pw_push_ready, 1);
        pw_push_valid = 1'b1;
        pw_push_addr  = addr_of(t);
        pw_push_tag   = t;
        @(negedge clk);
        pw_push_valid = 1'b0;
    endtask

    task automatic push_dl(input logic [1:0] k, input logic [TW-1:0] t);
        check(dl_push_ready, "R10 delayed ready", dl_push_ready, 1);
        dl_push_valid = 1'b1;
        dl_push_addr  = addr_of(t);
        dl_push_tag   = t;
        dl_push_kind  = k;
        @(negedge clk);
        dl_push_valid = 1'b0;
    endtask

    // waits for an offer, checks it, accepts it and returns a response
    task automatic serve(input bit ep, input logic [1:0] ek, input logic [TW-1:0] et,
                         input bit retry, input int hold, input string req);
        int n = 0;
        while (!iss_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(iss_valid, req, iss_valid, 1);
        check(iss_posted == ep, req, iss_posted, ep);
        check(iss_tag == et, req, iss_tag, et);
        check(iss_addr == addr_of(et), req, iss_addr, addr_of(et));
        if (!ep) check(iss_kind == ek, req, iss_kind, ek);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(iss_valid && iss_tag == et, "R11 held offer", iss_tag, et);
        end
        iss_ready = 1'b1;
        @(negedge clk);
        iss_ready = 1'b0;
        check(!iss_valid, "R11 no offer while outstanding", iss_valid, 0);
        rsp_done  = !retry;
        rsp_retry = retry;
        @(negedge clk);
        rsp_done  = 1'b0;
        rsp_retry = 1'b0;
    endtask

    // read request (R2), write request (R4), read completion (R3)
    task automatic test_wait_kind(input logic [1:0] k, input logic [TW-1:0] b, input string req);
        push_pw(b);
        push_pw(b + 1);
        push_dl(k, b + 2);
        serve(1'b1, 2'd0, b, 1'b0, 0, req);
        serve(1'b1, 2'd0, b + 1, 1'b0, 0, req);
        serve(1'b0, k, b + 2, 1'b0, 0, req);
    endtask

    task automatic test_r5();
        push_pw(8'd20);
        push_pw(8'd21);
        push_dl(2'd3, 8'd22);
        serve(1'b1, 2'd0, 8'd20, 1'b0, 0, "R5 first posted");
        serve(1'b0, 2'd3, 8'd22, 1'b0, 0, "R5 write cpl passes posted");
        serve(1'b1, 2'd0, 8'd21, 1'b0, 0, "R5 remaining posted");
    endtask

    task automatic test_r6_r8();
        push_pw(8'd30);
        push_dl(2'd0, 8'd31);
        push_pw(8'd32);
        serve(1'b1, 2'd0, 8'd30, 1'b0, 0, "R6 older posted");
        serve(1'b0, 2'd0, 8'd31, 1'b1, 0, "R8 delayed offered then retried");
        serve(1'b1, 2'd0, 8'd32, 1'b0, 0, "R6 posted passes retried delayed");
        serve(1'b0, 2'd0, 8'd31, 1'b0, 0, "R8 same entry re-offered");
    endtask

    task automatic test_r7_r13();
        push_pw(8'd40);
        push_pw(8'd41);
        push_dl(2'd3, 8'd42);
        push_dl(2'd3, 8'd43);
        serve(1'b1, 2'd0, 8'd40, 1'b0, 2, "R7 posted first");
        serve(1'b0, 2'd3, 8'd42, 1'b0, 0, "R7 alternate to delayed");
        serve(1'b1, 2'd0, 8'd41, 1'b0, 0, "R7 alternate to posted");
        serve(1'b0, 2'd3, 8'd43, 1'b0, 0, "R13 delayed order");
    endtask

    task automatic test_full_pw();
        for (int i = 0; i < 8; i++) push_pw(8'(50 + i));
        check(!pw_push_ready, "R10 posted full", pw_push_ready, 0);
        pw_push_valid = 1'b1;
        pw_push_addr  = addr_of(8'd99);
        pw_push_tag   = 8'd99;
        repeat (2) @(negedge clk);
        pw_push_valid = 1'b0;
        serve(1'b1, 2'd0, 8'd50, 1'b0, 0, "R1 posted order");
        check(pw_push_ready, "R10 ready after pop", pw_push_ready, 1);
        for (int i = 1; i < 8; i++) serve(1'b1, 2'd0, 8'(50 + i), 1'b0, 0, "R1 posted order");
    endtask

    task automatic test_full_dl();
        for (int i = 0; i < 8; i++) push_dl(2'd3, 8'(60 + i));
        check(!dl_push_ready, "R10 delayed full", dl_push_ready, 0);
        dl_push_valid = 1'b1;
        dl_push_addr  = addr_of(8'd98);
        dl_push_tag   = 8'd98;
        dl_push_kind  = 2'd3;
        repeat (2) @(negedge clk);
        dl_push_valid = 1'b0;
        for (int i = 0; i < 8; i++) serve(1'b0, 2'd3, 8'(60 + i), 1'b0, 0, "R13 delayed order");
    endtask

    task automatic test_idle_r9();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(!iss_valid, "R9 R10 nothing left to issue", iss_valid, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!iss_valid, "R12 reset valid", iss_valid, 0);
        check(pw_push_ready, "R12 reset posted ready", pw_push_ready, 1);
        check(dl_push_ready, "R12 reset delayed ready", dl_push_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!iss_valid, "R12 after reset", iss_valid, 0);
        test_wait_kind(2'd0, 8'd1, "R2 read request waits");
        test_wait_kind(2'd1, 8'd5, "R4 write request waits");
        test_wait_kind(2'd2, 8'd9, "R3 read completion waits");
        test_r5();
        test_r6_r8();
        test_r7_r13();
        test_full_pw();
        test_full_dl();
        test_idle_r9();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        report();
    end

endmodule